// File: doc/BRIEF.md
# Bit-Serial Elastic Store for Jitter Removal

This block smooths the timing of a serial bit stream. Bits arrive on a jittery line clock, each qualified by a valid strobe, and go into a small circular store. They leave on a second, smoothed clock whenever that domain raises a read tick. The store holds 32 cells. A two-bit mode input chooses how much of it is used: a 16-bit window, a 32-bit window, or no buffering at all. In the unbuffered case the selected stream's bit and valid go straight from input to output.

Each instance serves one channel that has a transmit stream and a receive stream. A path-select input decides which of the two goes through the store. The other stream is always wired straight through. The write pointer crosses into the smoothed domain as a Gray code. The fill level is computed there and presented as an output, so an external loop can trim the smoothed clock rate. A sticky limit flag reports that the fill level came within two bits of empty or of the selected depth. Pulsing the status-read input clears the flag and re-centres the store.

Streams carry valid strobes but no ready signal. The line side cannot be stalled and the read side emits one bit for every read tick, so neither side applies back-pressure. An overrun or underrun is absorbed by a re-centring slip, and the limit flag reports it.

Top module: `bit_elastic_store`

## Requirements
- R1: Mode encoding is 00 = bypass, 01 = 16-bit depth, 10 and 11 = 32-bit depth. After re-centring with no traffic, `fill_level` reads 8 in mode 01 and 16 in modes 10 and 11.
- R2: In mode 00 the selected stream's output bit and valid follow its input bit and valid combinationally. `fill_level` reads 0 and `limit_flag` is held at 0.
- R3: With `path_sel` = 0 the transmit stream is buffered and the receive stream is passed through combinationally. With `path_sel` = 1 the roles swap. The buffered output's valid stays low without read ticks, even while its input valid is high.
- R4: In buffered mode the output bit sequence equals the input bit sequence in order, at a constant offset, when write and read strobes follow irregular patterns with equal average rate.
- R5: In buffered mode each read tick produces exactly one output valid, in the following smoothed-clock cycle.
- R6: `limit_flag` becomes 1 when the fill level is at most 2 or at least the selected depth minus 2. It stays 0 at fills from 3 up to the depth minus 3.
- R7: Once set, `limit_flag` stays 1 while the fill level returns to a safe range, until a status read or a change to bypass.
- R8: A one-cycle `stat_rd` pulse clears `limit_flag` and re-centres the store, so the fill level returns to half the selected depth.
- R9: A change of mode between buffered depths re-centres the store at half the new depth.
- R10: If the fill level exceeds the selected depth, the store re-centres to half depth, and `limit_flag` is set.
- R11: A read tick at fill level 0 re-centres the store to half depth.
- R12: `rst_n` asserts asynchronously in both domains and releases synchronously. While it is low, `fill_level` and `limit_flag` are 0. After release the store re-centres at half depth with `limit_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line clock carrying both input streams |
| smooth_clk | input | 1 | Dejittered clock for the read side |
| rst_n | input | 1 | Active-low reset for both domains |
| mode | input | 2 | Depth/bypass select (R1 encoding) |
| path_sel | input | 1 | 0 buffers transmit, 1 buffers receive |
| tx_in_bit | input | 1 | Transmit stream data bit |
| tx_in_vld | input | 1 | Transmit stream bit strobe |
| rx_in_bit | input | 1 | Receive stream data bit |
| rx_in_vld | input | 1 | Receive stream bit strobe |
| rd_tick | input | 1 | Read strobe in the smoothed domain |
| stat_rd | input | 1 | Status read pulse: clear flag, re-centre |
| tx_out_bit | output | 1 | Transmit stream output bit |
| tx_out_vld | output | 1 | Transmit stream output strobe |
| rx_out_bit | output | 1 | Receive stream output bit |
| rx_out_vld | output | 1 | Receive stream output strobe |
| fill_level | output | 6 | Fill level seen in the smoothed domain |
| limit_flag | output | 1 | Sticky near-limit indicator |

## Verification
The buffered path is driven in two ways. First, a pseudo-random bit sequence is sent with bursty write strobes against spread-out read strobes of equal rate, in both depths and on both paths. This separates correct ordering and constant delay from dropped, duplicated or reordered bits. Second, single write or read strobes are issued one at a time, which steps the fill level across each limit boundary, past full, and below empty. That isolates the exact threshold values, the stickiness of the flag, and the slip behaviour. Bypass and the unselected path are probed with input toggles checked combinationally. That separates the straight-through wiring from the registered buffered output.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [1:0] {
    ES_BYPASS = 2'b00,
    ES_SHORT  = 2'b01,
    ES_LONG   = 2'b10,
    ES_LONG_B = 2'b11
  } es_mode_e;
endpackage

// File: rtl/es_rst_sync.sv
module es_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/es_gray_sync.sv
module es_gray_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= gray_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(stage_q[STAGES-1] >> i);
  end
endmodule

// File: rtl/es_write_side.sv
module es_write_side #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic [AW:0]   wr_gray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] cells_q;
  logic [PW-1:0]    wr_ptr_q;
  logic [PW-1:0]    wr_ptr_d;

  assign wr_ptr_d = wr_ptr_q + PW'(1);

  always_ff @(posedge clk) begin
    if (wr_en) cells_q[wr_ptr_q[AW-1:0]] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      wr_gray  <= '0;
    end else if (wr_en) begin
      wr_ptr_q <= wr_ptr_d;
      wr_gray  <= wr_ptr_d ^ (wr_ptr_d >> 1);
    end
  end

  assign rd_bit = cells_q[rd_addr];

  // R4
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/es_read_side.sv
module es_read_side
  import es_pkg::*;
#(
  parameter int AW    = 5,
  parameter int GUARD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_in,
  input  logic          rd_tick,
  input  logic          stat_rd,
  input  logic [AW:0]   wr_bin,
  input  logic          cell_bit,
  output logic [AW-1:0] rd_addr,
  output logic          out_bit,
  output logic          out_vld,
  output logic [AW:0]   fill,
  output logic          limit
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  es_mode_e      mode_s_q, mode_q;
  logic [PW-1:0] rd_ptr_q;
  logic          pend_q;
  logic          active;
  logic          mode_chg;
  logic [PW-1:0] depth_w, half_w, fill_c;
  logic          near_lim, over, under;

  assign active   = (mode_q != ES_BYPASS);
  assign mode_chg = (mode_s_q != mode_q);
  assign depth_w  = (mode_q == ES_SHORT) ? PW'(DEPTH / 2) : PW'(DEPTH);
  assign half_w   = depth_w >> 1;
  assign fill_c   = wr_bin - rd_ptr_q;
  assign near_lim = (fill_c <= PW'(GUARD)) || (fill_c >= depth_w - PW'(GUARD));
  assign over     = active && (fill_c > depth_w);
  assign under    = active && rd_tick && (fill_c == '0);
  assign rd_addr  = rd_ptr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_s_q <= ES_BYPASS;
      mode_q   <= ES_BYPASS;
    end else begin
      mode_s_q <= es_mode_e'(mode_in);
      mode_q   <= mode_s_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      pend_q   <= 1'b1;
    end else if (pend_q) begin
      rd_ptr_q <= wr_bin - half_w;
      pend_q   <= mode_chg || stat_rd;
    end else if (stat_rd || mode_chg || over || under) begin
      pend_q   <= 1'b1;
    end else if (active && rd_tick) begin
      rd_ptr_q <= rd_ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bit <= 1'b0;
      out_vld <= 1'b0;
      fill    <= '0;
      limit   <= 1'b0;
    end else begin
      out_vld <= active && rd_tick;
      if (active && rd_tick) out_bit <= cell_bit;
      fill <= active ? fill_c : '0;
      if (stat_rd || !active)      limit <= 1'b0;
      else if (!pend_q && near_lim) limit <= 1'b1;
    end
  end

  // R7
  limit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit && !stat_rd && mode_s_q != ES_BYPASS) |=> limit);
  // R8
  limit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !limit);
  // R8
  flush_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> pend_q);
  // R5
  out_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(rd_tick));
endmodule

// File: rtl/bit_elastic_store.sv
module bit_elastic_store
  import es_pkg::*;
#(
  parameter int AW          = 5,
  parameter int GUARD       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        line_clk,
  input  logic        smooth_clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        path_sel,
  input  logic        tx_in_bit,
  input  logic        tx_in_vld,
  input  logic        rx_in_bit,
  input  logic        rx_in_vld,
  input  logic        rd_tick,
  input  logic        stat_rd,
  output logic        tx_out_bit,
  output logic        tx_out_vld,
  output logic        rx_out_bit,
  output logic        rx_out_vld,
  output logic [AW:0] fill_level,
  output logic        limit_flag
);
  localparam int PW = AW + 1;

  logic          wr_rst_n, rd_rst_n;
  logic          buf_on, wr_en, wr_bit;
  logic [PW-1:0] wr_gray, wr_bin;
  logic [AW-1:0] rd_addr;
  logic          cell_bit, q_bit, q_vld;

  es_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(line_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  es_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(smooth_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  assign buf_on = (es_mode_e'(mode) != ES_BYPASS);
  assign wr_bit = path_sel ? rx_in_bit : tx_in_bit;
  assign wr_en  = buf_on && (path_sel ? rx_in_vld : tx_in_vld);

  es_write_side #(.AW(AW)) u_wr (
    .clk(line_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_addr(rd_addr), .rd_bit(cell_bit), .wr_gray(wr_gray));

  es_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_ptr_sync (
    .clk(smooth_clk), .rst_n(rd_rst_n), .gray_in(wr_gray), .bin_out(wr_bin));

  es_read_side #(.AW(AW), .GUARD(GUARD)) u_rd (
    .clk(smooth_clk), .rst_n(rd_rst_n), .mode_in(mode), .rd_tick(rd_tick),
    .stat_rd(stat_rd), .wr_bin(wr_bin), .cell_bit(cell_bit),
    .rd_addr(rd_addr), .out_bit(q_bit), .out_vld(q_vld),
    .fill(fill_level), .limit(limit_flag));

  always_comb begin
    tx_out_bit = tx_in_bit;
    tx_out_vld = tx_in_vld;
    rx_out_bit = rx_in_bit;
    rx_out_vld = rx_in_vld;
    if (buf_on && !path_sel) begin
      tx_out_bit = q_bit;
      tx_out_vld = q_vld;
    end
    if (buf_on && path_sel) begin
      rx_out_bit = q_bit;
      rx_out_vld = q_vld;
    end
  end
endmodule

// File: tb/bit_elastic_store_bench.sv
`timescale 1ns/1ps
module bit_elastic_store_bench;
  logic       line_clk = 0, smooth_clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b01;
  logic       path_sel = 0;
  logic       tx_in_bit = 0, tx_in_vld = 0, rx_in_bit = 0, rx_in_vld = 0;
  logic       rd_tick = 0, stat_rd = 0;
  logic       tx_out_bit, tx_out_vld, rx_out_bit, rx_out_vld;
  logic [5:0] fill_level;
  logic       limit_flag;

  int n_chk = 0, n_err = 0;
  bit wbits [512];
  bit rbits [512];
  int nw, nr;
  logic [6:0] prbs = 7'h5A;

  always #4 line_clk = ~line_clk;
  initial begin #3; forever #4 smooth_clk = ~smooth_clk; end

  bit_elastic_store u_bit_elastic_store (
    .line_clk(line_clk), .smooth_clk(smooth_clk), .rst_n(rst_n), .mode(mode),
    .path_sel(path_sel), .tx_in_bit(tx_in_bit), .tx_in_vld(tx_in_vld),
    .rx_in_bit(rx_in_bit), .rx_in_vld(rx_in_vld), .rd_tick(rd_tick),
    .stat_rd(stat_rd), .tx_out_bit(tx_out_bit), .tx_out_vld(tx_out_vld),
    .rx_out_bit(rx_out_bit), .rx_out_vld(rx_out_vld),
    .fill_level(fill_level), .limit_flag(limit_flag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wait_s(input int n);
    for (int i = 0; i < n; i++) @(negedge smooth_clk);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge line_clk);
      if (path_sel) rx_in_vld = 1; else tx_in_vld = 1;
    end
    @(negedge line_clk);
    tx_in_vld = 0; rx_in_vld = 0;
    wait_s(8);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge smooth_clk); rd_tick = 1;
    end
    @(negedge smooth_clk); rd_tick = 0;
    wait_s(4);
  endtask

  task automatic status_read();
    @(negedge smooth_clk); stat_rd = 1;
    @(negedge smooth_clk); stat_rd = 0;
    wait_s(6);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge smooth_clk); mode = m;
    wait_s(10);
  endtask

  task automatic t_reset();
    rst_n = 0; wait_s(3);
    chk_eq("R12 fill in reset", int'(fill_level), 0);
    chk_eq("R12 flag in reset", int'(limit_flag), 0);
    @(negedge smooth_clk); rst_n = 1;
    wait_s(12);
    chk_eq("R12 fill after reset", int'(fill_level), 8);
    chk_eq("R12 flag after reset", int'(limit_flag), 0);
  endtask

  task automatic t_modes();
    set_mode(2'b10);
    chk_eq("R1 mode 10 centre", int'(fill_level), 16);
    set_mode(2'b11);
    chk_eq("R1 mode 11 centre", int'(fill_level), 16);
    set_mode(2'b01);
    chk_eq("R1 mode 01 centre", int'(fill_level), 8);
  endtask

  task automatic t_mode_change();
    set_mode(2'b10);
    write_n(4);
    chk_eq("R9 fill before change", int'(fill_level), 20);
    set_mode(2'b01);
    chk_eq("R9 fill after change", int'(fill_level), 8);
  endtask

  task automatic t_limits();
    status_read();
    chk_eq("R8 start flag", int'(limit_flag), 0);
    write_n(5);
    chk_eq("R6 fill 13", int'(fill_level), 13);
    chk_eq("R6 flag at 13", int'(limit_flag), 0);
    write_n(1);
    chk_eq("R6 flag at 14", int'(limit_flag), 1);
    read_n(6);
    chk_eq("R7 fill back to 8", int'(fill_level), 8);
    chk_eq("R7 flag sticky", int'(limit_flag), 1);
    status_read();
    chk_eq("R8 flag cleared", int'(limit_flag), 0);
    chk_eq("R8 fill centred", int'(fill_level), 8);
    read_n(5);
    chk_eq("R6 flag at 3", int'(limit_flag), 0);
    read_n(1);
    chk_eq("R6 flag at 2", int'(limit_flag), 1);
    status_read();
    chk_eq("R8 fill after low clear", int'(fill_level), 8);
  endtask

  task automatic t_slips();
    write_n(9);
    chk_eq("R10 fill after overrun", int'(fill_level), 8);
    chk_eq("R10 flag after overrun", int'(limit_flag), 1);
    status_read();
    read_n(8);
    chk_eq("R11 fill at empty", int'(fill_level), 0);
    read_n(1);
    chk_eq("R11 fill after underrun", int'(fill_level), 8);
  endtask

  task automatic t_tick();
    set_mode(2'b10);
    status_read();
    chk_eq("R5 idle valid", int'(tx_out_vld), 0);
    @(negedge smooth_clk); rd_tick = 1;
    @(negedge smooth_clk); rd_tick = 0;
    chk_eq("R5 valid after tick", int'(tx_out_vld), 1);
    @(negedge smooth_clk);
    chk_eq("R5 single valid", int'(tx_out_vld), 0);
  endtask

  task automatic t_path();
    set_mode(2'b01);
    path_sel = 0;
    @(negedge line_clk); rx_in_bit = 1; rx_in_vld = 1; tx_in_vld = 1; #1;
    chk_eq("R3 rx passes bit", int'(rx_out_bit), 1);
    chk_eq("R3 rx passes vld", int'(rx_out_vld), 1);
    chk_eq("R3 tx buffered vld", int'(tx_out_vld), 0);
    @(negedge line_clk); rx_in_bit = 0; rx_in_vld = 0; tx_in_vld = 0;
    path_sel = 1;
    @(negedge line_clk); tx_in_bit = 1; tx_in_vld = 1; rx_in_vld = 1; #1;
    chk_eq("R3 tx passes bit", int'(tx_out_bit), 1);
    chk_eq("R3 rx buffered vld", int'(rx_out_vld), 0);
    @(negedge line_clk); tx_in_bit = 0; tx_in_vld = 0; rx_in_vld = 0;
    path_sel = 0;
    status_read();
  endtask

  task automatic t_bypass();
    set_mode(2'b01);
    write_n(6);
    set_mode(2'b00);
    @(negedge line_clk); tx_in_bit = 1; tx_in_vld = 1; #1;
    chk_eq("R2 bypass bit high", int'(tx_out_bit), 1);
    chk_eq("R2 bypass vld", int'(tx_out_vld), 1);
    @(negedge line_clk); tx_in_bit = 0; tx_in_vld = 0; #1;
    chk_eq("R2 bypass bit low", int'(tx_out_bit), 0);
    chk_eq("R2 bypass vld low", int'(tx_out_vld), 0);
    wait_s(6);
    chk_eq("R2 bypass fill", int'(fill_level), 0);
    chk_eq("R2 bypass flag", int'(limit_flag), 0);
  endtask

  task automatic t_stream(input logic [1:0] m, input bit p, input int cycles);
    bit [7:0] wpat = 8'b0001_1111;
    bit [7:0] rpat = 8'b1010_1101;
    int found = 0;
    path_sel = p;
    set_mode(m);
    status_read();
    nw = 0; nr = 0;
    fork
      begin
        for (int c = 0; c < cycles; c++) begin
          @(negedge line_clk);
          if (wpat[c % 8]) begin
            prbs = {prbs[5:0], prbs[6] ^ prbs[5]};
            wbits[nw] = prbs[0];
            nw++;
            if (p) begin rx_in_bit = prbs[0]; rx_in_vld = 1; end
            else   begin tx_in_bit = prbs[0]; tx_in_vld = 1; end
          end else begin
            tx_in_vld = 0; rx_in_vld = 0;
          end
        end
        @(negedge line_clk); tx_in_vld = 0; rx_in_vld = 0;
      end
      begin
        for (int c = 0; c < cycles + 3; c++) begin
          @(negedge smooth_clk);
          if (p ? rx_out_vld : tx_out_vld) begin
            rbits[nr] = p ? rx_out_bit : tx_out_bit;
            nr++;
          end
          rd_tick = (c < cycles) && rpat[c % 8];
        end
      end
    join
    for (int o = 1; o <= 48; o++) begin
      bit ok = 1;
      for (int j = 48; j < nr; j++) begin
        if (j - o >= nw) ok = 0;
        else if (rbits[j] != wbits[j - o]) ok = 0;
      end
      if (ok) found++;
    end
    chk_eq("R4 read count", nr, nw);
    chk_eq("R4 ordered constant offset", found, 1);
    if (m == 2'b10) chk_eq("R4 no limit hit", int'(limit_flag), 0);
    path_sel = 0;
  endtask

  initial begin
    #(8ns * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_mode_change();
    t_limits();
    t_slips();
    t_tick();
    t_path();
    t_bypass();
    t_stream(2'b10, 1'b0, 320);
    t_stream(2'b01, 1'b1, 320);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule